// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block turns edges on general-purpose input pins into interrupt requests for sixteen interrupt lines. Line n always watches pin n. The pin comes from one of several ports, and a 4-bit source code per line picks the port. The selected pin passes through a two-flop synchronizer. A rising edge, a falling edge, or either edge on the synchronized value can then set a sticky pending bit for that line, as chosen by two per-line trigger-enable bits.

A per-line enable bit gates both the setting of a pending bit and the request that leaves the block. Each line drives its own request output, and one combined output is the OR of all sixteen line requests. A request stays high until software clears its pending bit by writing a one to that bit position. If the handler does not clear the bit, the request is still present when the handler returns.

Software reaches the configuration and the pending bits through a plain synchronous register port. A write takes effect at the clock edge that samples it. A read strobe returns data one clock later. Every pin on this port is a control signal, so the port has no valid/ready handshake and no back-pressure.

Top module: `pin_edge_irq`

## Requirements
- R1: After reset, every enable, trigger, pending and source-code register is 0, so every line selects port 0. `irq_line` and `irq_any` are 0.
- R2: Register word addresses are: 0 = line enable, 1 = rising-trigger enable, 2 = falling-trigger enable, 3 = pending (write one to clear), 4 to 7 = source-code words. `reg_rdata` shows the addressed value at the clock edge after a cycle with `reg_rd` high. Bits 31:16 and unmapped addresses read 0.
- R3: With the line's enable bit and rising-trigger bit both 1, a 0-to-1 change on the selected pin sets the pending bit at the third rising clock edge after the change, and not before.
- R4: With the falling-trigger bit set, a 1-to-0 change sets the pending bit with the same latency. With only the other trigger bit set, that change has no effect. With both trigger bits set, both kinds of change set the bit.
- R5: An edge on a line whose enable bit is 0 does not set its pending bit.
- R6: A pending bit stays set until a register write to address 3 has a 1 in that bit position. Writing 0 to a pending bit leaves it unchanged.
- R7: When an enabled edge and a write-one-to-clear reach the same line in the same cycle, the pending bit stays set.
- R8: Line n takes its source code from word 4 + n/4, bits (n%4)*4 + 3 down to (n%4)*4. Code p selects bit p*16 + n of `port_pins`. A code of `NUM_PORTS` or higher selects a constant 0, so that line sees no edges.
- R9: `irq_line[n]` is high exactly when pending bit n and enable bit n are both 1. `irq_any` is the OR of `irq_line`. Clearing an enable bit drops the request but keeps the pending bit readable.
- R10: Edges on pin n of a port that line n does not select do not affect line n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| port_pins | input | NUM_PORTS*16 | Raw pins; port p pin n at bit p*16+n |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after `reg_rd` |
| irq_line | output | 16 | Per-line interrupt request |
| irq_any | output | 1 | OR of all line requests |

## Verification
The edge path is driven with single rising changes, single falling changes and round trips on lines that have one trigger enabled or both. This separates which edge kinds are detected from the fixed three-clock latency, which is sampled one clock early as well as on time. Source selection is tried by toggling the same pin number on a port that is not selected, and then on the selected port, including an out-of-range code. These patterns show whether the multiplexer and the packed field positions are right. Pending behaviour is tried with writes of zero, plain clears, a clear that lands in the same cycle as a new edge, and an enable bit turned off while a request is pending.

// File: rtl/pin_edge_irq_pkg.sv
package pin_edge_irq_pkg;
  localparam int LINES        = 16;
  localparam int SEL_W        = 4;
  localparam int SEL_PER_WORD = 4;
  localparam int SEL_WORDS    = LINES / SEL_PER_WORD;
  localparam int WORD_BITS    = SEL_W * SEL_PER_WORD;

  localparam int A_ENABLE = 0;
  localparam int A_RISE   = 1;
  localparam int A_FALL   = 2;
  localparam int A_PEND   = 3;
  localparam int A_SEL0   = 4;
endpackage

// File: rtl/pie_src_select.sv
module pie_src_select
  import pin_edge_irq_pkg::*;
#(
  parameter int NUM_PORTS = 3
) (
  input  logic [NUM_PORTS*LINES-1:0] pins,
  input  logic [LINES*SEL_W-1:0]     sel,
  output logic [LINES-1:0]           src
);
  always_comb begin
    for (int n = 0; n < LINES; n++) begin
      src[n] = 1'b0;
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (sel[n*SEL_W +: SEL_W] == SEL_W'(p)) src[n] = pins[p*LINES + n];
      end
    end
  end
endmodule

// File: rtl/pie_line_sync.sv
module pie_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_en,
  input  logic fall_en,
  output logic edge_pulse
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= pin;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign edge_pulse = (rise_en & sync_q & ~prev_q) | (fall_en & ~sync_q & prev_q);
endmodule

// File: rtl/pie_regfile.sv
module pie_regfile
  import pin_edge_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr,
  input  logic                   rd,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wdata,
  input  logic [LINES-1:0]       edge_hit,
  output logic [LINES-1:0]       enable,
  output logic [LINES-1:0]       rise,
  output logic [LINES-1:0]       fall,
  output logic [LINES-1:0]       pend,
  output logic [LINES*SEL_W-1:0] sel,
  output logic [DATA_W-1:0]      rdata
);
  logic [LINES-1:0]  clr_bits;
  logic [DATA_W-1:0] rd_val;

  assign clr_bits = (wr && addr == ADDR_W'(A_PEND)) ? wdata[LINES-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable <= '0;
      rise   <= '0;
      fall   <= '0;
      pend   <= '0;
      sel    <= '0;
    end else begin
      pend <= (pend & ~clr_bits) | edge_hit;
      if (wr) begin
        if (addr == ADDR_W'(A_ENABLE)) enable <= wdata[LINES-1:0];
        if (addr == ADDR_W'(A_RISE))   rise   <= wdata[LINES-1:0];
        if (addr == ADDR_W'(A_FALL))   fall   <= wdata[LINES-1:0];
        for (int w = 0; w < SEL_WORDS; w++) begin
          if (addr == ADDR_W'(A_SEL0 + w)) sel[w*WORD_BITS +: WORD_BITS] <= wdata[WORD_BITS-1:0];
        end
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (addr == ADDR_W'(A_ENABLE)) rd_val[LINES-1:0] = enable;
    if (addr == ADDR_W'(A_RISE))   rd_val[LINES-1:0] = rise;
    if (addr == ADDR_W'(A_FALL))   rd_val[LINES-1:0] = fall;
    if (addr == ADDR_W'(A_PEND))   rd_val[LINES-1:0] = pend;
    for (int w = 0; w < SEL_WORDS; w++) begin
      if (addr == ADDR_W'(A_SEL0 + w)) rd_val[WORD_BITS-1:0] = sel[w*WORD_BITS +: WORD_BITS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= rd_val;
  end
endmodule

// File: rtl/pin_edge_irq.sv
module pin_edge_irq
  import pin_edge_irq_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PORTS*LINES-1:0] port_pins,
  input  logic                       reg_wr,
  input  logic                       reg_rd,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [DATA_W-1:0]          reg_wdata,
  output logic [DATA_W-1:0]          reg_rdata,
  output logic [LINES-1:0]           irq_line,
  output logic                       irq_any
);
  logic [LINES-1:0]       enable_q, rise_q, fall_q, pend_q;
  logic [LINES*SEL_W-1:0] sel_q;
  logic [LINES-1:0]       src_pin, line_edge, edge_hit;

  pie_src_select #(.NUM_PORTS(NUM_PORTS)) u_sel (
    .pins (port_pins),
    .sel  (sel_q),
    .src  (src_pin)
  );

  for (genvar n = 0; n < LINES; n++) begin : g_line
    pie_line_sync u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin        (src_pin[n]),
      .rise_en    (rise_q[n]),
      .fall_en    (fall_q[n]),
      .edge_pulse (line_edge[n])
    );
  end

  assign edge_hit = line_edge & enable_q;

  pie_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr),
    .rd       (reg_rd),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .edge_hit (edge_hit),
    .enable   (enable_q),
    .rise     (rise_q),
    .fall     (fall_q),
    .pend     (pend_q),
    .sel      (sel_q),
    .rdata    (reg_rdata)
  );

  assign irq_line = pend_q & enable_q;
  assign irq_any  = |irq_line;
endmodule

// File: rtl/pie_checker.sv
module pie_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [3:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [15:0] pend,
  input logic [15:0] enable,
  input logic [15:0] edge_hit
);
  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == 4'd3) |=> ((pend & $past(pend)) == $past(pend))); // R6

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 4'd3) |=> ((pend & $past(reg_wdata[15:0]) & ~$past(edge_hit)) == 16'd0)); // R6

  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_hit) |=> ((pend & $past(edge_hit)) == $past(edge_hit))); // R7

  AST_MASK_GATES_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~$past(pend) & ~$past(enable)) == 16'd0); // R5
endmodule

bind pin_edge_irq pie_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .pend      (pend_q),
  .enable    (enable_q),
  .edge_hit  (edge_hit)
);

// File: tb/sim_pin_edge_irq.sv
module sim_pin_edge_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] port_pins = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] irq_line;
  logic        irq_any;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic rd_seen = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  pin_edge_irq u0 (
    .clk(clk), .rst_n(rst_n), .port_pins(port_pins),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_line(irq_line), .irq_any(irq_any)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  // driver: pushes the expected value, the monitor compares it
  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string req);
    exp_q.push_back(e); tag_q.push_back(req);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  always @(posedge clk) rd_seen <= reg_rd;

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    check("R1 irq_line", {16'd0, irq_line}, 32'd0);
    check("R1 irq_any", {31'd0, irq_any}, 32'd0);
    for (int a = 0; a < 8; a++) rd(4'(a), 32'd0, "R1 reg");
    rd(4'd9, 32'd0, "R2 unmapped");
    // R2 map, upper bits zero
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd0, 32'h0000_FFFF, "R2 upper");
    wr(4'd0, 32'h3); wr(4'd1, 32'h1); wr(4'd2, 32'h2);
    rd(4'd1, 32'h1, "R2 rise");
    rd(4'd2, 32'h2, "R2 fall");
    // R3 rising edge latency on line 0
    port_pins[0] = 1'b1;
    tick(2); check("R3 early", {16'd0, irq_line}, 32'd0);
    tick(1); check("R3 set", {16'd0, irq_line}, 32'h1);
    check("R9 any", {31'd0, irq_any}, 32'd1);
    rd(4'd3, 32'h1, "R3 pend");
    // R6 sticky, zero write ignored, one clears
    port_pins[0] = 1'b0;
    tick(5); check("R6 sticky", {16'd0, irq_line}, 32'h1);
    wr(4'd3, 32'h0); check("R6 zero write", {16'd0, irq_line}, 32'h1);
    wr(4'd3, 32'h1); check("R6 clear", {16'd0, irq_line}, 32'h0);
    rd(4'd3, 32'h0, "R6 pend");
    // R4 falling edge on line 1
    port_pins[1] = 1'b1;
    tick(4); check("R4 rise ignored", {16'd0, irq_line}, 32'h0);
    port_pins[1] = 1'b0;
    tick(3); check("R4 fall", {16'd0, irq_line}, 32'h2);
    wr(4'd3, 32'h2);
    // R4 both edges on line 0
    wr(4'd2, 32'h3);
    port_pins[0] = 1'b1;
    tick(3); check("R4 both rise", {16'd0, irq_line}, 32'h1);
    wr(4'd3, 32'h1);
    port_pins[0] = 1'b0;
    tick(3); check("R4 both fall", {16'd0, irq_line}, 32'h1);
    wr(4'd3, 32'h1);
    // R5 disabled line 2
    wr(4'd1, 32'h5);
    port_pins[2] = 1'b1;
    tick(4); rd(4'd3, 32'h0, "R5 masked");
    port_pins[2] = 1'b0;
    // R9 enable off keeps pending
    port_pins[0] = 1'b1;
    tick(3); wr(4'd0, 32'h2);
    check("R9 line off", {16'd0, irq_line}, 32'h0);
    check("R9 any off", {31'd0, irq_any}, 32'd0);
    rd(4'd3, 32'h1, "R9 pend kept");
    wr(4'd0, 32'h3); check("R9 line on", {16'd0, irq_line}, 32'h1);
    port_pins[0] = 1'b0;
    tick(3); wr(4'd3, 32'h1);
    // R10 / R8 line 0 moved to port 1
    wr(4'd4, 32'h1); tick(2);
    port_pins[0] = 1'b1;
    tick(4); check("R10 other port", {16'd0, irq_line}, 32'h0);
    port_pins[0] = 1'b0; tick(4);
    port_pins[16] = 1'b1;
    tick(3); check("R8 port1", {16'd0, irq_line}, 32'h1);
    port_pins[16] = 1'b0; tick(3); wr(4'd3, 32'h1);
    // R8 line 5 on port 2, field bits 7:4 of word 5
    wr(4'd0, 32'h23); wr(4'd1, 32'h25); wr(4'd5, 32'h20);
    rd(4'd5, 32'h20, "R8 sel word");
    port_pins[37] = 1'b1;
    tick(3); check("R8 line5", {16'd0, irq_line}, 32'h20);
    port_pins[37] = 1'b0;
    wr(4'd3, 32'h20); check("R8 line5 clr", {16'd0, irq_line}, 32'h0);
    // R8 out-of-range code
    wr(4'd4, 32'h3); tick(2);
    port_pins[0] = 1'b1; port_pins[16] = 1'b1; port_pins[32] = 1'b1;
    tick(4); check("R8 code3 rise", {16'd0, irq_line}, 32'h0);
    port_pins[0] = 1'b0; port_pins[16] = 1'b0; port_pins[32] = 1'b0;
    tick(4); check("R8 code3 fall", {16'd0, irq_line}, 32'h0);
    // R7 edge and clear in one cycle
    wr(4'd4, 32'h0); tick(3);
    port_pins[0] = 1'b1;
    tick(3); check("R7 pre", {16'd0, irq_line}, 32'h1);
    port_pins[0] = 1'b0;
    tick(2); wr(4'd3, 32'h1);
    check("R7 edge wins", {16'd0, irq_line}, 32'h1);
    rd(4'd3, 32'h1, "R7 pend");
    wr(4'd3, 32'h1); check("R7 plain clear", {16'd0, irq_line}, 32'h0);
    tick(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule